// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block produces the status word that a parallel NOR flash returns on its data bus while an internal program or erase algorithm runs. It tracks the operating mode and the set of sectors chosen for erasure. On every read it returns either array data or a status word that carries two toggle bits and a timeout flag. Command decoding, the cell array and analog timing sit outside. The block only receives single-cycle command strobes, the read enables, the sector being read, a per-sector protect mask and the internal pulse counter.

The two toggle bits answer different questions. The busy toggle (bit 6) shows whether an algorithm is running chip-wide. It freezes while an erase is suspended. The sector toggle (bit 2) shows whether the sector being read is one that is queued for erase. Software needs both bits to tell an active erase from a suspended one, and to tell which sectors are affected. A program aimed at a protected sector shows a short busy burst and then falls back to array reads.

Top module: `flash_op_status`

## Requirements
- R1: After reset the block is idle, and in idle `dq_o` equals `array_data_i`.
- R2: A read starts on the rising edge of `oe_i & ce_i`, so either enable can open it. In program, erase, suspended-program and protect-abort modes, bit 6 of the status word inverts at each read start.
- R3: While an erase is suspended, bit 6 holds its value. Reads of sectors not selected for erase return array data. Reads of selected sectors return the status word.
- R4: `erase_sel_i` is captured with the erase command and takes effect from the next cycle. While that erase is pending (running, suspended or under a suspended program), bit 2 inverts on each read start of a selected sector. Reads of unselected sectors leave bit 2 unchanged. When no erase is pending the selection is empty.
- R5: A program command to a sector whose `protect_mask_i` bit is set shows toggling status for `ABORT_CYC` cycles and then returns to idle. During an erase suspend, such a command is ignored.
- R6: Bit 5 becomes 1 once `pulse_cnt_i >= PULSE_LIMIT` while program, erase or suspended-program is running. It stays set, and `op_done_i` is then ignored, until a reset command arrives.
- R7: `cmd_reset_i` returns the block to idle from any mode. It clears bit 5 and the erase selection.
- R8: `op_done_i` ends a program or an erase (to idle) and ends a suspended program (back to erase suspend). `cmd_suspend_i` moves an erase to suspend, and `cmd_resume_i` moves it back.
- R9: The status word has bit 6 as the busy toggle, bit 5 as the timeout flag, bit 2 as the sector toggle, and all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_prog_i | input | 1 | Program command accepted (one cycle) |
| cmd_erase_i | input | 1 | Sector erase command accepted (one cycle) |
| cmd_suspend_i | input | 1 | Erase suspend command |
| cmd_resume_i | input | 1 | Erase resume command |
| cmd_reset_i | input | 1 | Reset command, return to array read |
| prog_sector_i | input | SECT_W | Sector targeted by the program command |
| erase_sel_i | input | NUM_SECT | Sectors chosen by the erase command |
| protect_mask_i | input | NUM_SECT | Per-sector protection |
| op_done_i | input | 1 | Internal algorithm finished |
| pulse_cnt_i | input | PCNT_W | Internal pulse counter |
| oe_i | input | 1 | Output enable, active high |
| ce_i | input | 1 | Chip enable, active high |
| rd_sector_i | input | SECT_W | Sector of the current read address |
| array_data_i | input | DATA_W | Data from the cell array |
| dq_o | output | DATA_W | Read data bus |

## Verification
Assertions check the following on every cycle: the busy toggle flips on every read start in a running mode, and it is frozen in suspend. A read of an unselected sector never moves the sector toggle. The selection is empty whenever no erase is pending. The abort mode can only end in idle. The timeout flag is sticky, and a reset command always lands in idle. The bench scenarios cover the rest. These are the exact status words seen across a program, an erase, a suspend with an embedded program, and a resume. They also include a read opened by the chip enable, the length of the protect window, the ignored protected program during suspend, and the fact that `op_done_i` has no effect after a timeout.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  typedef enum logic [2:0] {
    M_IDLE,
    M_PROG,
    M_ERASE,
    M_ESUSP,
    M_ESPROG,
    M_PABORT
  } mode_e;

  // busy toggle advances on reads
  function automatic logic busy_toggles(mode_e m);
    return (m == M_PROG) || (m == M_ERASE) || (m == M_ESPROG) || (m == M_PABORT);
  endfunction

  // algorithm consuming pulses
  function automatic logic alg_running(mode_e m);
    return (m == M_PROG) || (m == M_ERASE) || (m == M_ESPROG);
  endfunction

  function automatic logic erase_pending(mode_e m);
    return (m == M_ERASE) || (m == M_ESUSP) || (m == M_ESPROG);
  endfunction

endpackage

// File: rtl/flash_mode_ctrl.sv
module flash_mode_ctrl
  import flash_status_pkg::*;
#(
  parameter int PCNT_W      = 12,
  parameter int PULSE_LIMIT = 1000,
  parameter int ABORT_CYC   = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_prog_i,
  input  logic              cmd_erase_i,
  input  logic              cmd_suspend_i,
  input  logic              cmd_resume_i,
  input  logic              cmd_reset_i,
  input  logic              prog_protected_i,
  input  logic              op_done_i,
  input  logic [PCNT_W-1:0] pulse_cnt_i,
  output mode_e             mode_o,
  output logic              fail_o,
  output logic              mask_load_o,
  output logic              mask_clr_o
);

  localparam int                CNT_W   = $clog2(ABORT_CYC + 1);
  localparam logic [PCNT_W-1:0] LIMIT_V = PCNT_W'(PULSE_LIMIT);
  localparam logic [CNT_W-1:0]  ABORT_V = CNT_W'(ABORT_CYC - 1);

  mode_e            mode_q, mode_d;
  logic             fail_q, fail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    mode_d      = mode_q;
    fail_d      = fail_q;
    cnt_d       = cnt_q;
    mask_load_o = 1'b0;
    if (cmd_reset_i) begin
      mode_d = M_IDLE;
      fail_d = 1'b0;
      cnt_d  = '0;
    end else begin
      if (alg_running(mode_q) && (pulse_cnt_i >= LIMIT_V)) fail_d = 1'b1;
      case (mode_q)
        M_IDLE: begin
          if (cmd_erase_i) begin
            mode_d      = M_ERASE;
            mask_load_o = 1'b1;
          end else if (cmd_prog_i) begin
            if (prog_protected_i) begin
              mode_d = M_PABORT;
              cnt_d  = ABORT_V;
            end else begin
              mode_d = M_PROG;
            end
          end
        end
        M_PROG:   if (op_done_i && !fail_q) mode_d = M_IDLE;
        M_ERASE: begin
          if (!fail_q) begin
            if (op_done_i)          mode_d = M_IDLE;
            else if (cmd_suspend_i) mode_d = M_ESUSP;
          end
        end
        M_ESUSP: begin
          if (cmd_resume_i)                          mode_d = M_ERASE;
          else if (cmd_prog_i && !prog_protected_i)  mode_d = M_ESPROG;
        end
        M_ESPROG: if (op_done_i && !fail_q) mode_d = M_ESUSP;
        M_PABORT: begin
          if (cnt_q == '0) mode_d = M_IDLE;
          else             cnt_d  = cnt_q - 1'b1;
        end
        default: mode_d = M_IDLE;
      endcase
    end
  end

  assign mask_clr_o = !erase_pending(mode_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_IDLE;
      fail_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      fail_q <= fail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign mode_o = mode_q;
  assign fail_o = fail_q;

  p_abort_exit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_PABORT) |=> (mode_q == M_PABORT) || (mode_q == M_IDLE));

  p_fail_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_q && !cmd_reset_i) |=> fail_q);

  p_reset_cmd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_reset_i |=> (mode_q == M_IDLE) && !fail_q);

endmodule

// File: rtl/flash_erase_map.sv
module flash_erase_map #(
  parameter int NUM_SECT = 8,
  parameter int SECT_W   = $clog2(NUM_SECT)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                clr_i,
  input  logic [NUM_SECT-1:0] sel_i,
  input  logic [SECT_W-1:0]   rd_sector_i,
  output logic [NUM_SECT-1:0] mask_o,
  output logic                hit_o
);

  logic [NUM_SECT-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mask_q <= '0;
    else if (load_i) mask_q <= sel_i;
    else if (clr_i)  mask_q <= '0;
  end

  assign mask_o = mask_q;
  assign hit_o  = mask_q[rd_sector_i];

endmodule

// File: rtl/flash_toggle_gen.sv
module flash_toggle_gen
  import flash_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              oe_i,
  input  logic              ce_i,
  input  mode_e             mode_i,
  input  logic              sel_hit_i,
  input  logic              fail_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] dq_o
);

  localparam int BIT_BUSY = 6;
  localparam int BIT_FAIL = 5;
  localparam int BIT_SECT = 2;

  logic rd_q, rd_edge;
  logic busy_tog_q, sect_tog_q;
  logic show_status;
  logic [DATA_W-1:0] status_w;

  assign rd_edge = oe_i && ce_i && !rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q       <= 1'b0;
      busy_tog_q <= 1'b0;
      sect_tog_q <= 1'b0;
    end else begin
      rd_q <= oe_i && ce_i;
      if (rd_edge && busy_toggles(mode_i)) busy_tog_q <= !busy_tog_q;
      if (rd_edge && sel_hit_i)            sect_tog_q <= !sect_tog_q;
    end
  end

  // suspended erase: only selected sectors report status
  assign show_status = (mode_i != M_IDLE) && !((mode_i == M_ESUSP) && !sel_hit_i);

  always_comb begin
    status_w           = '0;
    status_w[BIT_BUSY] = busy_tog_q;
    status_w[BIT_FAIL] = fail_i;
    status_w[BIT_SECT] = sect_tog_q;
  end

  assign dq_o = show_status ? status_w : array_data_i;

  p_busy_flip_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_edge && busy_toggles(mode_i)) |=> (busy_tog_q != $past(busy_tog_q)));

  p_busy_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_ESUSP) |=> $stable(busy_tog_q));

  p_sect_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_hit_i |=> $stable(sect_tog_q));

endmodule

// File: rtl/flash_op_status.sv
module flash_op_status
  import flash_status_pkg::*;
#(
  parameter int NUM_SECT    = 8,
  parameter int SECT_W      = $clog2(NUM_SECT),
  parameter int DATA_W      = 8,
  parameter int PCNT_W      = 12,
  parameter int PULSE_LIMIT = 1000,
  parameter int ABORT_CYC   = 200
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_prog_i,
  input  logic                cmd_erase_i,
  input  logic                cmd_suspend_i,
  input  logic                cmd_resume_i,
  input  logic                cmd_reset_i,
  input  logic [SECT_W-1:0]   prog_sector_i,
  input  logic [NUM_SECT-1:0] erase_sel_i,
  input  logic [NUM_SECT-1:0] protect_mask_i,
  input  logic                op_done_i,
  input  logic [PCNT_W-1:0]   pulse_cnt_i,
  input  logic                oe_i,
  input  logic                ce_i,
  input  logic [SECT_W-1:0]   rd_sector_i,
  input  logic [DATA_W-1:0]   array_data_i,
  output logic [DATA_W-1:0]   dq_o
);

  mode_e               mode;
  logic                fail, mask_load, mask_clr, sel_hit, prog_protected;
  logic [NUM_SECT-1:0] mask;

  assign prog_protected = protect_mask_i[prog_sector_i];

  flash_mode_ctrl #(
    .PCNT_W     (PCNT_W),
    .PULSE_LIMIT(PULSE_LIMIT),
    .ABORT_CYC  (ABORT_CYC)
  ) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .cmd_prog_i      (cmd_prog_i),
    .cmd_erase_i     (cmd_erase_i),
    .cmd_suspend_i   (cmd_suspend_i),
    .cmd_resume_i    (cmd_resume_i),
    .cmd_reset_i     (cmd_reset_i),
    .prog_protected_i(prog_protected),
    .op_done_i       (op_done_i),
    .pulse_cnt_i     (pulse_cnt_i),
    .mode_o          (mode),
    .fail_o          (fail),
    .mask_load_o     (mask_load),
    .mask_clr_o      (mask_clr)
  );

  flash_erase_map #(
    .NUM_SECT(NUM_SECT),
    .SECT_W  (SECT_W)
  ) u_map (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (mask_load),
    .clr_i      (mask_clr),
    .sel_i      (erase_sel_i),
    .rd_sector_i(rd_sector_i),
    .mask_o     (mask),
    .hit_o      (sel_hit)
  );

  flash_toggle_gen #(
    .DATA_W(DATA_W)
  ) u_tog (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .oe_i        (oe_i),
    .ce_i        (ce_i),
    .mode_i      (mode),
    .sel_hit_i   (sel_hit),
    .fail_i      (fail),
    .array_data_i(array_data_i),
    .dq_o        (dq_o)
  );

  p_mask_empty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !erase_pending(mode) |-> (mask == '0));

  p_idle_array_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == M_IDLE) |-> (dq_o == array_data_i));

endmodule

// File: tb/flash_op_status_bench.sv
`timescale 1ns/1ps
module flash_op_status_bench;

  localparam int NUM_SECT    = 8;
  localparam int SECT_W      = 3;
  localparam int DATA_W      = 8;
  localparam int PCNT_W      = 12;
  localparam int PULSE_LIMIT = 1000;
  localparam int ABORT_CYC   = 200;
  localparam logic [7:0] ARR = 8'hA5;

  localparam logic [3:0] OP_RD = 4'd0, OP_PROG = 4'd1, OP_ERASE = 4'd2, OP_SUSP = 4'd3,
                         OP_RES = 4'd4, OP_DONE = 4'd5, OP_RST = 4'd6, OP_RDCE = 4'd7;

  // {op, sector, expected dq}
  localparam logic [15:0] VEC [0:28] = '{
    16'h00A5,                                     // R1 idle array read
    16'h1300, 16'h0340, 16'h7000, 16'h0340,       // R2 program, read via oe and ce
    16'h5000, 16'h03A5,                           // R8 done -> idle
    16'h2000, 16'h0104, 16'h0240, 16'h0500, 16'h0144, // R4 erase, unselected keeps bit 2, R9 layout
    16'h3000, 16'h0140, 16'h0244, 16'h05A5,       // R3 suspend
    16'h1400, 16'h0404, 16'h0140,                 // R2 suspended program
    16'h5000, 16'h0244,                           // R8 back to suspend
    16'h4000, 16'h0504, 16'h5000, 16'h01A5,       // R8 resume, done
    16'h2000, 16'h0140, 16'h6000, 16'h01A5        // R7 reset command
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_prog = 0, cmd_erase = 0, cmd_susp = 0, cmd_res = 0, cmd_rst = 0, op_done = 0;
  logic [SECT_W-1:0] prog_sector = '0, rd_sector = '0;
  logic [PCNT_W-1:0] pulse_cnt = '0;
  logic oe = 1'b0, ce = 1'b1;
  logic [DATA_W-1:0] dq;
  int checks = 0, fails = 0;
  bit done_run = 0;

  always #2.5 clk = ~clk;

  flash_op_status #(
    .NUM_SECT(NUM_SECT), .SECT_W(SECT_W), .DATA_W(DATA_W), .PCNT_W(PCNT_W),
    .PULSE_LIMIT(PULSE_LIMIT), .ABORT_CYC(ABORT_CYC)
  ) u_flash_op_status (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_prog_i(cmd_prog), .cmd_erase_i(cmd_erase), .cmd_suspend_i(cmd_susp),
    .cmd_resume_i(cmd_res), .cmd_reset_i(cmd_rst),
    .prog_sector_i(prog_sector), .erase_sel_i(8'h06), .protect_mask_i(8'h80),
    .op_done_i(op_done), .pulse_cnt_i(pulse_cnt),
    .oe_i(oe), .ce_i(ce), .rd_sector_i(rd_sector),
    .array_data_i(ARR), .dq_o(dq)
  );

  task automatic chk(input logic [7:0] exp, input string tag);
    checks++;
    if (dq !== exp) begin
      fails++;
      $display("FAIL %s: dq=%h expected=%h", tag, dq, exp);
    end
  endtask

  task automatic cmd(input logic [3:0] op, input logic [SECT_W-1:0] sec);
    @(negedge clk);
    prog_sector = sec;
    case (op)
      OP_PROG:  cmd_prog  = 1;
      OP_ERASE: cmd_erase = 1;
      OP_SUSP:  cmd_susp  = 1;
      OP_RES:   cmd_res   = 1;
      OP_DONE:  op_done   = 1;
      OP_RST:   cmd_rst   = 1;
      default: ;
    endcase
    @(negedge clk);
    {cmd_prog, cmd_erase, cmd_susp, cmd_res, op_done, cmd_rst} = '0;
  endtask

  task automatic rd(input logic [SECT_W-1:0] sec, input bit via_ce,
                    input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_sector = sec;
    if (via_ce) begin
      oe = 1; ce = 0;
      @(negedge clk);
      ce = 1;
    end else begin
      oe = 1;
    end
    @(negedge clk);
    chk(exp, tag);
    oe = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ARR, "R1 reset state");
    rst_ni = 1;
    @(negedge clk);
    chk(ARR, "R1 after reset");

    for (int i = 0; i < 29; i++) begin
      logic [3:0] op;
      op = VEC[i][15:12];
      if (op == OP_RD || op == OP_RDCE)
        rd(VEC[i][10:8], op == OP_RDCE, VEC[i][7:0], $sformatf("vec %0d R2/R3/R4/R8/R9", i));
      else
        cmd(op, VEC[i][10:8]);
    end
    // toggles now: busy=1, sector=0

    // R5 protected program aborts after window
    cmd(OP_PROG, 3'd7);
    rd(3'd7, 0, 8'h00, "R5 abort toggles");
    rd(3'd7, 0, 8'h40, "R5 abort toggles again");
    repeat (ABORT_CYC - 20) @(negedge clk);
    rd(3'd7, 0, 8'h00, "R5 still inside window");
    repeat (30) @(negedge clk);
    rd(3'd7, 0, ARR, "R5 window over");

    // R6 timeout flag, sticky
    cmd(OP_PROG, 3'd3);
    @(negedge clk);
    pulse_cnt = PCNT_W'(PULSE_LIMIT);
    rd(3'd3, 0, 8'h60, "R6 timeout flag set");
    cmd(OP_DONE, 3'd0);
    rd(3'd3, 0, 8'h20, "R6 done ignored after timeout");
    cmd(OP_RST, 3'd0);
    rd(3'd3, 0, ARR, "R7 reset clears timeout");
    rd(3'd3, 0, ARR, "R6 idle ignores pulse count");
    pulse_cnt = '0;

    // R5 protected program ignored in suspend
    cmd(OP_ERASE, 3'd0);
    cmd(OP_SUSP, 3'd0);
    cmd(OP_PROG, 3'd7);
    rd(3'd5, 0, ARR, "R5 protected program ignored in suspend");
    rd(3'd1, 0, 8'h04, "R3 suspend status after ignored program");
    cmd(OP_RST, 3'd0);
    rd(3'd1, 0, ARR, "R7 reset from suspend");

    done_run = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done_run) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule